// File: doc/BRIEF.md
# Serial Real-Time Clock with Battery-Backed Word Store

This block is a slave device on a four-wire serial link, oversampled by the system clock. It holds a 32-bit seconds counter that advances on a one-cycle 1 Hz tick, a small word store for values such as a time bias, two timer words, a snapshot word, four read-only test words, and a control pair that reports supply health. A host reaches every register with one chip-select window of 64 clocks. The first 32 bits are a command word and the next 32 bits are the data word.

In the command word, bit 31 selects the direction: 1 is a write and 0 is a read. Bits 30:8 carry the register address, zero-extended to 24 bits, and bits 7:0 are ignored. For a read, the device shifts the addressed value out during the second word. For a write, the host shifts the value in, and the device commits it only when the 64th bit arrives. Read and write permissions are decoded separately, so some addresses answer reads but ignore writes. The tick, power-fail and low-battery inputs are assumed synchronous to `clk`. The serial pins pass through a synchronizer of `SYNC_STAGES` flops.

Top module: `rtc_serial_clock`

## Requirements
- R1: Both words are sent MSB first. The device samples `spi_mosi` on rising `spi_sclk`. During a read, `spi_miso` presents data bit 31 before the 33rd rising edge and moves to the next bit after each later rising edge. `spi_miso` is 0 outside a frame. Command bits 7:0 have no effect on the access.
- R2: If `spi_cs_n` rises before the 64th rising edge of a write frame, the device writes nothing.
- R3: The counter at address 0x200000 can be read and written. It adds one for each `tick_1hz` pulse and wraps from 0xFFFFFFFF to 0.
- R4: A write commits on the `SYNC_STAGES+1`th rising `clk` edge after the 64th `spi_sclk` rise. A counter write loads the written value exactly, and a tick sampled on that same edge is discarded.
- R5: `SRAM_WORDS` storage words from 0x200001 upward are readable and writable, and each holds its own value. The word at 0x200004 is the bias slot.
- R6: A write to 0x204000 ignores its data and latches the current counter value. A read of 0x204000 returns the latched value, even after the counter moves on.
- R7: The timer words at 0x210000 and 0x210001 are plain read/write storage.
- R8: Addresses 0x210004 to 0x210007 read as `TEST_SEED + n`, where n is 0 to 3. Writes to them are ignored.
- R9: Address 0x21000C is read-only. Its bit 11 is the unstable-power flag, its bit 9 follows `low_batt`, and every other bit reads 0.
- R10: A `pwr_fail` pulse sets the unstable-power flag. The flag stays set until a write to 0x21000D, which clears it and stores its data for read-back. If `pwr_fail` arrives on the same edge as that write, the flag stays set.
- R11: A read from an unmapped address returns 0. A write to an unmapped address changes nothing.
- R12: After reset, every register reads 0, the flag is clear and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| tick_1hz | input | 1 | One-cycle seconds pulse |
| pwr_fail | input | 1 | Pulse that sets the unstable-power flag |
| low_batt | input | 1 | Live low-battery level |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, sixteen storage words and a fixed test seed. These values give a commit edge at a known clock offset. That lets the bench place a tick exactly on the load edge, and one edge after it, to separate the discarded tick from the counted one. Sixteen words are enough to cover the bias slot, the last word at 0x200010, and the unmapped address just past it.

// File: rtl/rtc_pkg.sv
// Shared address constants and the region type for the serial real-time clock.
// Assumes a 32-bit frame word and 24-bit register addresses.
package rtc_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 24;

    localparam logic [ADDR_W-1:0] A_COUNT   = 24'h200000;
    localparam logic [ADDR_W-1:0] A_SNAP    = 24'h204000;
    localparam logic [ADDR_W-1:0] A_TMR_ON  = 24'h210000;
    localparam logic [ADDR_W-1:0] A_TMR_OFF = 24'h210001;
    localparam logic [ADDR_W-1:0] A_TEST    = 24'h210004;
    localparam logic [ADDR_W-1:0] A_CTRL0   = 24'h21000C;
    localparam logic [ADDR_W-1:0] A_CTRL1   = 24'h21000D;

    localparam int TEST_REGS    = 4;
    localparam int BIT_UNSTABLE = 11;
    localparam int BIT_LOWBAT   = 9;

    typedef enum logic [3:0] {
        RGN_NONE,
        RGN_COUNT,
        RGN_STORE,
        RGN_SNAP,
        RGN_TMR_ON,
        RGN_TMR_OFF,
        RGN_TEST,
        RGN_CTRL0,
        RGN_CTRL1
    } region_e;
endpackage

// File: rtl/rtc_pin_sync.sv
// Brings the serial pins into the clk domain and finds the rising edge of sclk.
// Assumes sclk half-periods are longer than STAGES+1 clk cycles.
module rtc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise_o,
    output logic frame_active_o,
    output logic mosi_o
);
    // Each stage holds {sclk, cs_n, mosi}.
    logic [2:0] chain [STAGES];
    logic       sclk_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first capture of the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 3'b010;
                else        chain[0] <= {sclk_i, cs_n_i, mosi_i};
            end
        end else begin : g_next
            // Purpose: later stage of the metastability chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 3'b010;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    // Purpose: delayed sclk, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= chain[STAGES-1][2];
    end

    assign sclk_rise_o    = chain[STAGES-1][2] & ~sclk_d;
    assign frame_active_o = ~chain[STAGES-1][1];
    assign mosi_o         = chain[STAGES-1][0];
endmodule

// File: rtl/rtc_frame_engine.sv
// Shifts in the command and data words, looks up read data when the command
// word completes, and shifts it out MSB first. Assumes synchronized inputs.
module rtc_frame_engine #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              frame_active,
    input  logic              mosi_bit,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              miso
);
    localparam int FRAME_BITS = 2 * WORD_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int HDR_W      = WORD_W - 8;

    logic [WORD_W-1:0] in_sr;
    logic [WORD_W-1:0] out_sr;
    logic [HDR_W-1:0]  cmd_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shift_word;
    logic              take;
    logic              cmd_valid;

    assign shift_word = {in_sr[WORD_W-2:0], mosi_bit};
    assign take       = sclk_rise && frame_active && (bit_cnt < CNT_W'(FRAME_BITS));
    assign cmd_valid  = take && (bit_cnt == CNT_W'(WORD_W - 1));
    assign rd_addr    = {1'b0, shift_word[WORD_W-2:8]};
    assign wr_valid   = take && (bit_cnt == CNT_W'(FRAME_BITS - 1)) && cmd_q[HDR_W-1];
    assign wr_addr    = {1'b0, cmd_q[HDR_W-2:0]};
    assign wr_data    = shift_word;
    assign miso       = out_sr[WORD_W-1] & frame_active;

    // Purpose: input shift register, bit counter and command capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_active) begin
            in_sr   <= '0;
            bit_cnt <= '0;
            cmd_q   <= '0;
        end else if (take) begin
            in_sr   <= shift_word;
            bit_cnt <= bit_cnt + 1'b1;
            if (cmd_valid) cmd_q <= shift_word[WORD_W-1:8];
        end
    end

    // Purpose: load read data on command completion, then shift it out.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_active) begin
            out_sr <= '0;
        end else if (cmd_valid) begin
            out_sr <= shift_word[WORD_W-1] ? '0 : rd_data;
        end else if (take && bit_cnt >= CNT_W'(WORD_W)) begin
            out_sr <= {out_sr[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/rtc_regfile.sv
// Address map with separate read and write permissions, the seconds counter,
// storage words, snapshot, timers, test words and supply-status flags.
// Assumes tick, pwr_fail and low_batt are synchronous to clk.
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int          SRAM_WORDS = 16,
    parameter logic [31:0] TEST_SEED  = 32'hA5C3_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tick,
    input  logic              pwr_fail,
    input  logic              low_batt,
    output logic [WORD_W-1:0] count_q,
    output logic              count_load,
    output logic [WORD_W-1:0] snap_q,
    output logic              snap_wr,
    output logic              unstable_q,
    output logic              ctl1_wr
);
    localparam int IDX_W  = (SRAM_WORDS > 1) ? $clog2(SRAM_WORDS) : 1;
    localparam int TIDX_W = $clog2(TEST_REGS);
    localparam logic [ADDR_W-1:0] A_STORE_LO = A_COUNT + 1;
    localparam logic [ADDR_W-1:0] A_STORE_HI = A_COUNT + ADDR_W'(SRAM_WORDS);

    logic [WORD_W-1:0] store [SRAM_WORDS];
    logic [WORD_W-1:0] tmr_on_q, tmr_off_q, ctl1_q;
    region_e           rd_rgn, wr_rgn;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [TIDX_W-1:0] test_idx;
    logic              store_wr;

    function automatic region_e classify(input logic [ADDR_W-1:0] a);
        if (a == A_COUNT)                         return RGN_COUNT;
        if (a >= A_STORE_LO && a <= A_STORE_HI)   return RGN_STORE;
        if (a == A_SNAP)                          return RGN_SNAP;
        if (a == A_TMR_ON)                        return RGN_TMR_ON;
        if (a == A_TMR_OFF)                       return RGN_TMR_OFF;
        if (a >= A_TEST && a < A_TEST + ADDR_W'(TEST_REGS)) return RGN_TEST;
        if (a == A_CTRL0)                         return RGN_CTRL0;
        if (a == A_CTRL1)                         return RGN_CTRL1;
        return RGN_NONE;
    endfunction

    assign rd_rgn   = classify(rd_addr);
    assign wr_rgn   = wr_en ? classify(wr_addr) : RGN_NONE;
    assign rd_idx   = IDX_W'(rd_addr - A_STORE_LO);
    assign wr_idx   = IDX_W'(wr_addr - A_STORE_LO);
    assign test_idx = TIDX_W'(rd_addr - A_TEST);

    // Write permissions: test words and control0 are absent, so those writes drop.
    assign count_load = (wr_rgn == RGN_COUNT);
    assign store_wr   = (wr_rgn == RGN_STORE);
    assign snap_wr    = (wr_rgn == RGN_SNAP);
    assign ctl1_wr    = (wr_rgn == RGN_CTRL1);

    // Purpose: read multiplexer, returning zero for unmapped addresses.
    always_comb begin
        rd_data = '0;
        unique case (rd_rgn)
            RGN_COUNT:   rd_data = count_q;
            RGN_STORE:   rd_data = store[rd_idx];
            RGN_SNAP:    rd_data = snap_q;
            RGN_TMR_ON:  rd_data = tmr_on_q;
            RGN_TMR_OFF: rd_data = tmr_off_q;
            RGN_TEST:    rd_data = TEST_SEED + WORD_W'(test_idx);
            RGN_CTRL0: begin
                rd_data[BIT_UNSTABLE] = unstable_q;
                rd_data[BIT_LOWBAT]   = low_batt;
            end
            RGN_CTRL1:   rd_data = ctl1_q;
            default:     rd_data = '0;
        endcase
    end

    // Purpose: seconds counter; a load wins over a tick on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (count_load) count_q <= wr_data;
        else if (tick)       count_q <= count_q + 1'b1;
    end

    // Purpose: storage words, including the bias slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SRAM_WORDS; i++) store[i] <= '0;
        end else if (store_wr) begin
            store[wr_idx] <= wr_data;
        end
    end

    // Purpose: snapshot latch, timers and control1 storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q    <= '0;
            tmr_on_q  <= '0;
            tmr_off_q <= '0;
            ctl1_q    <= '0;
        end else begin
            if (snap_wr)                 snap_q    <= count_q;
            if (wr_rgn == RGN_TMR_ON)    tmr_on_q  <= wr_data;
            if (wr_rgn == RGN_TMR_OFF)   tmr_off_q <= wr_data;
            if (ctl1_wr)                 ctl1_q    <= wr_data;
        end
    end

    // Purpose: sticky unstable-power flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        unstable_q <= 1'b0;
        else if (pwr_fail) unstable_q <= 1'b1;
        else if (ctl1_wr)  unstable_q <= 1'b0;
    end
endmodule

// File: rtl/rtc_serial_clock.sv
// Top of the serial real-time clock: pin synchronizer, frame engine, register file.
// Assumes the host keeps each sclk half-period above SYNC_STAGES+1 clk cycles.
module rtc_serial_clock
    import rtc_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          SRAM_WORDS  = 16,
    parameter logic [31:0] TEST_SEED   = 32'hA5C3_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    input  logic tick_1hz,
    input  logic pwr_fail,
    input  logic low_batt
);
    logic              sclk_rise, frame_active, mosi_bit;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [WORD_W-1:0] rd_data, wr_data;
    logic              wr_valid;
    logic [WORD_W-1:0] count_q, snap_q;
    logic              count_load, snap_wr, unstable_q, ctl1_wr;

    rtc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk            (clk),
        .rst_n          (rst_n),
        .sclk_i         (spi_sclk),
        .cs_n_i         (spi_cs_n),
        .mosi_i         (spi_mosi),
        .sclk_rise_o    (sclk_rise),
        .frame_active_o (frame_active),
        .mosi_o         (mosi_bit)
    );

    rtc_frame_engine #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_rise    (sclk_rise),
        .frame_active (frame_active),
        .mosi_bit     (mosi_bit),
        .rd_data      (rd_data),
        .rd_addr      (rd_addr),
        .wr_valid     (wr_valid),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .miso         (spi_miso)
    );

    rtc_regfile #(.SRAM_WORDS(SRAM_WORDS), .TEST_SEED(TEST_SEED)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_en      (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tick       (tick_1hz),
        .pwr_fail   (pwr_fail),
        .low_batt   (low_batt),
        .count_q    (count_q),
        .count_load (count_load),
        .snap_q     (snap_q),
        .snap_wr    (snap_wr),
        .unstable_q (unstable_q),
        .ctl1_wr    (ctl1_wr)
    );
endmodule

// File: rtl/rtc_serial_clock_chk.sv
// Property checker for the serial real-time clock, bound to the top module.
module rtc_serial_clock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1hz,
    input logic        pwr_fail,
    input logic        count_load,
    input logic [31:0] wr_data,
    input logic [31:0] count_q,
    input logic        snap_wr,
    input logic [31:0] snap_q,
    input logic        unstable_q,
    input logic        ctl1_wr
);
    assert_tick_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !count_load) |=> count_q == $past(count_q) + 32'd1);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !count_load) |=> $stable(count_q));

    assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_load |=> count_q == $past(wr_data));

    assert_snap_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snap_wr |=> snap_q == $past(count_q));

    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> unstable_q);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (unstable_q && !ctl1_wr) |=> unstable_q);
endmodule

bind rtc_serial_clock rtc_serial_clock_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .pwr_fail   (pwr_fail),
    .count_load (count_load),
    .wr_data    (wr_data),
    .count_q    (count_q),
    .snap_wr    (snap_wr),
    .snap_q     (snap_q),
    .unstable_q (unstable_q),
    .ctl1_wr    (ctl1_wr)
);

// File: tb/rtc_serial_clock_tb.sv
module rtc_serial_clock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int SYNC       = 2;
    localparam logic [31:0] SEED = 32'hA5C3_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic tick = 1'b0, pfail = 1'b0, lowb = 1'b0;
    int   n_checks = 0, n_fails = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_serial_clock #(.SYNC_STAGES(SYNC), .SRAM_WORDS(16), .TEST_SEED(SEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .tick_1hz(tick),
        .pwr_fail(pfail), .low_batt(lowb)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit w, input logic [23:0] a, input logic [7:0] lo);
        return {w, a[22:0], lo};
    endfunction

    // One frame of nbits; tick_at > 0 raises tick for the clk edge of that
    // index counted from the final sclk rise.
    task automatic xfer(input logic [31:0] cmd, input logic [31:0] data,
                        input int nbits, input int tick_at, output logic [31:0] rd);
        rd = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            mosi = (b < 32) ? cmd[31-b] : data[63-b];
            repeat (HALF) @(negedge clk);
            if (b >= 32) rd[63-b] = miso;
            sclk = 1'b1;
            for (int c = 1; c <= HALF; c++) begin
                @(negedge clk);
                tick = (b == nbits - 1) && (c == tick_at - 1);
            end
            sclk = 1'b0;
        end
        tick = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        logic [31:0] junk;
        xfer(mk(1'b1, a, 8'h00), d, 64, 0, junk);
    endtask

    task automatic rd(input logic [23:0] a, output logic [31:0] v);
        xfer(mk(1'b0, a, 8'h00), 32'h0, 64, 0, v);
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R12 miso idle", {31'b0, miso}, 32'h0);
        rd(24'h200000, v); check("R12 counter", v, 32'h0);
        rd(24'h21000C, v); check("R12 control0", v, 32'h0);
        rd(24'h21000D, v); check("R12 control1", v, 32'h0);
        rd(24'h200004, v); check("R12 bias word", v, 32'h0);
    endtask

    task automatic t_counter;
        logic [31:0] v;
        wr(24'h200000, 32'd100);
        pulse_ticks(5);
        rd(24'h200000, v); check("R3 count up", v, 32'd105);
        wr(24'h200000, 32'hFFFF_FFFE);
        pulse_ticks(3);
        rd(24'h200000, v); check("R3 wrap", v, 32'd1);
        xfer(mk(1'b0, 24'h200000, 8'hFF), 32'h0, 64, 0, v);
        check("R1 low command byte ignored", v, 32'd1);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        xfer(mk(1'b1, 24'h200000, 8'h00), 32'd500, 64, SYNC + 1, v);
        rd(24'h200000, v); check("R4 tick on load edge dropped", v, 32'd500);
        xfer(mk(1'b1, 24'h200000, 8'h00), 32'd600, 64, SYNC + 2, v);
        rd(24'h200000, v); check("R4 tick after load counted", v, 32'd601);
    endtask

    task automatic t_store;
        logic [31:0] v;
        for (int i = 0; i < 16; i++) wr(24'h200001 + 24'(i), 32'hC0DE_0000 + 32'(i * 7));
        for (int i = 0; i < 16; i++) begin
            rd(24'h200001 + 24'(i), v);
            check("R5 store word", v, 32'hC0DE_0000 + 32'(i * 7));
        end
        wr(24'h200004, 32'h1234_5678);
        rd(24'h200004, v); check("R5 bias slot", v, 32'h1234_5678);
        rd(24'h200005, v); check("R5 neighbour kept", v, 32'hC0DE_0000 + 32'd28);
    endtask

    task automatic t_snapshot;
        logic [31:0] v;
        wr(24'h200000, 32'd7000);
        wr(24'h204000, 32'hDEAD_BEEF);
        pulse_ticks(3);
        rd(24'h200000, v); check("R6 counter moved", v, 32'd7003);
        rd(24'h204000, v); check("R6 snapshot latched", v, 32'd7000);
    endtask

    task automatic t_timers;
        logic [31:0] v;
        wr(24'h210000, 32'h8000_0001);
        wr(24'h210001, 32'h7FFF_FFFE);
        rd(24'h210000, v); check("R7 R1 on timer MSB/LSB", v, 32'h8000_0001);
        rd(24'h210001, v); check("R7 off timer", v, 32'h7FFF_FFFE);
    endtask

    task automatic t_test_regs;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            rd(24'h210004 + 24'(i), v);
            check("R8 test word", v, SEED + 32'(i));
        end
        wr(24'h210006, 32'h0);
        rd(24'h210006, v); check("R8 test write ignored", v, SEED + 32'd2);
    endtask

    task automatic t_control;
        logic [31:0] v;
        lowb = 1'b1;
        rd(24'h21000C, v); check("R9 low battery bit", v, 32'h0000_0200);
        @(negedge clk) pfail = 1'b1;
        @(negedge clk) pfail = 1'b0;
        rd(24'h21000C, v); check("R10 flag set", v, 32'h0000_0A00);
        wr(24'h21000C, 32'h0);
        rd(24'h21000C, v); check("R9 control0 write ignored", v, 32'h0000_0A00);
        wr(24'h21000D, 32'h55);
        rd(24'h21000C, v); check("R10 flag cleared", v, 32'h0000_0200);
        rd(24'h21000D, v); check("R10 control1 stored", v, 32'h55);
        lowb = 1'b0;
        rd(24'h21000C, v); check("R9 low battery live", v, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(24'h200010, 32'hAAAA_5555);
        wr(24'h200011, 32'h0000_0123);
        rd(24'h200011, v); check("R11 unmapped reads zero", v, 32'h0);
        rd(24'h200010, v); check("R11 last word untouched", v, 32'hAAAA_5555);
        rd(24'h300000, v); check("R11 far unmapped", v, 32'h0);
    endtask

    task automatic t_abort;
        logic [31:0] v;
        wr(24'h200000, 32'd777);
        xfer(mk(1'b1, 24'h200000, 8'h00), 32'd999, 40, 0, v);
        rd(24'h200000, v); check("R2 abort at 40 bits", v, 32'd777);
        xfer(mk(1'b1, 24'h200000, 8'h00), 32'd999, 63, 0, v);
        rd(24'h200000, v); check("R2 abort at 63 bits", v, 32'd777);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset;
        t_counter;
        t_collide;
        t_store;
        t_snapshot;
        t_timers;
        t_test_regs;
        t_control;
        t_unmapped;
        t_abort;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule